// File: doc/BRIEF.md
# Shared Transmit FIFO Pool Manager

This block divides one shared, word-wide storage pool into separate transmit FIFOs for a group of serial channels. Software gives each channel a start offset inside the pool and a half-length code `L`. The channel's region is then `2*(L+1)` words long. It works as two halves of `L+1` words each, used in ping-pong fashion, so fast channels can be given larger regions than slow ones. The usable pool is 64 words when sub-channelling is allowed (`sub_dis = 0`). It is 128 words when sub-channelling is disabled (`sub_dis = 1`), because the space otherwise held for sub-channel mapping is then added to the pool.

The fetch side works in half-buffer units. A channel that has a free half posts a fill request. The pending requests are offered one at a time on a valid/ready request port. The offer carries the channel and the number of words owed. Once the offer is accepted, exactly that many words are taken on a valid/ready write port. The serial side pulls one word at a time for a chosen channel. Each word of a transmit half gives the channel time to run between fetches. If a channel's FIFO is empty when it is read, the serial side receives a fixed idle word and the channel's underflow flag is set.

Back-pressure rules are as follows. An offer (`dreq_valid`) stays up, with channel and length unchanged, until `dreq_ready` is seen. `dwr_ready` is high only while a fill is in progress, and a word moves only when `dwr_valid` and `dwr_ready` are both high. `ser_rd_ready` is high only when the selected channel is enabled. A read handshake on an enabled channel always completes in the same cycle, with the data presented combinationally.

Changing the mode bit, or reconfiguring a channel while its offer or fill is outstanding, is not supported.

Top module: `txfifo_pool_mgr`

## Requirements
- R1: A configuration write with `cfg_en = 1` is rejected when `cfg_base + 2*(cfg_len+1)` is greater than the pool size (64 words if `sub_dis = 0`, 128 words if `sub_dis = 1`). `cfg_err` is registered: after each configuration write it shows 1 if that write was rejected and 0 if it was accepted.
- R2: A rejected write leaves the channel's previous configuration unchanged. A channel that was disabled stays disabled, with `ser_rd_ready` low.
- R3: An accepted write that enables a channel empties its FIFO and makes it owe two half fills.
- R4: A pending fill is offered with `dreq_valid`, together with `dreq_ch` and `dreq_len = cfg_len+1`. All three hold steady until `dreq_ready` is seen.
- R5: After an offer is accepted, `dwr_ready` is high for exactly `dreq_len` accepted words and is low afterwards. Only one fill is in progress at a time.
- R6: Serial reads return the words in the order they were written. Both pointers wrap inside the channel's own region, and the stored count never exceeds the region size.
- R7: When a serial read takes the last word of a half, that channel owes one more half fill and a new offer for it follows.
- R8: A serial read of an enabled channel whose FIFO is empty returns the idle word `0x7E7E7E7E`, and the channel's bit in `uflow` is set.
- R9: An underflow bit stays set until a `uf_clr_we` write has a 1 in that bit's position of `uf_clr_mask`. A 0 in that position leaves the bit as it is.
- R10: Pending fills are offered in round-robin order. The search starts at the channel after the last one offered. After reset that search starts at channel 0.
- R11: A read of a disabled channel sees `ser_rd_ready = 0` and has no effect on any FIFO or underflow bit.
- R12: After reset, `dreq_valid`, `dwr_ready`, `cfg_err` and `uflow` are all 0, and every channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_dis | input | 1 | 1 = sub-channelling off, pool is 128 words; 0 = pool is 64 words |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CW | Channel being configured |
| cfg_en | input | 1 | Enable for the channel |
| cfg_base | input | AW | Region start offset in words |
| cfg_len | input | AW-1 | Half-length code; each half holds cfg_len+1 words |
| cfg_err | output | 1 | 1 if the last configuration write was rejected |
| uf_clr_we | input | 1 | Underflow clear strobe |
| uf_clr_mask | input | NUM_CH | Write-one-to-clear mask for the underflow bits |
| uflow | output | NUM_CH | Sticky underflow bit per channel |
| dreq_valid | output | 1 | A fill offer is pending |
| dreq_ready | input | 1 | Fetch side accepts the offer |
| dreq_ch | output | CW | Channel to fill |
| dreq_len | output | AW+1 | Words owed for this fill |
| dwr_valid | input | 1 | Fill word present |
| dwr_ready | output | 1 | Fill in progress, word will be taken |
| dwr_data | input | DW | Fill word |
| ser_rd_valid | input | 1 | Serial side reads one word |
| ser_rd_ready | output | 1 | Selected channel is enabled |
| ser_ch | input | CW | Channel the serial side reads |
| ser_rd_data | output | DW | Word read, or the idle word if the FIFO is empty |

## Verification
The bench builds the block with `NUM_CH = 4`, `POOL_MAX = 128` and `DW = 32`. With only four channels, the round-robin search wraps past the top index after a few grants, so the rotation order can be seen directly. Short halves of two and four words make region wrap, half-boundary refill requests and underflow reachable within a handful of reads. A region placed at offsets 62 to 65 falls just past the 64-word limit and inside the 128-word limit, which exercises the mode-dependent rejection on both sides of the boundary.

// File: rtl/txfp_pkg.sv
package txfp_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OFFER = 2'd1,
    ARB_FILL  = 2'd2
  } arb_st_e;

  localparam logic [7:0] IDLE_BYTE = 8'h7E;

endpackage

// File: rtl/txfp_chan_ctx.sv
module txfp_chan_ctx #(
  parameter int AW = 7,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_base,
  input  logic [LW-1:0] ld_len,
  input  logic          rd_go,
  input  logic          rd_miss,
  input  logic          wr_go,
  input  logic          fill_done,
  input  logic          uf_clr,
  output logic          en,
  output logic [AW-1:0] base,
  output logic [AW:0]   half,
  output logic [AW:0]   size,
  output logic [AW:0]   wptr,
  output logic [AW:0]   rptr,
  output logic [AW:0]   count,
  output logic [1:0]    need,
  output logic          uflow,
  output logic          empty
);

  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [LW-1:0] len_q;
  logic [AW:0]   rptr_inc, wptr_inc;
  logic [AW:0]   rptr_nx, wptr_nx;
  logic          half_hit;

  assign half  = (AW+1)'(len_q) + ONE;
  assign size  = half << 1;
  assign empty = (count == '0);

  assign rptr_inc = rptr + ONE;
  assign wptr_inc = wptr + ONE;
  assign rptr_nx  = (rptr_inc == size) ? '0 : rptr_inc;
  assign wptr_nx  = (wptr_inc == size) ? '0 : wptr_inc;
  assign half_hit = rd_go && ((rptr_inc == half) || (rptr_inc == size));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      base  <= '0;
      len_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      need  <= '0;
    end else if (load) begin
      en    <= ld_en;
      base  <= ld_base;
      len_q <= ld_len;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      need  <= ld_en ? 2'd2 : 2'd0;
    end else begin
      if (wr_go) wptr <= wptr_nx;
      if (rd_go) rptr <= rptr_nx;
      count <= count + (AW+1)'(wr_go) - (AW+1)'(rd_go);
      need  <= need + 2'(half_hit) - 2'(fill_done);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) uflow <= 1'b0;
    else        uflow <= (uflow && !uf_clr) || rd_miss;
  end

endmodule

// File: rtl/txfp_rr_pick.sv
module txfp_rr_pick #(
  parameter int N  = 32,
  parameter int CW = 5
) (
  input  logic [N-1:0]  req,
  input  logic [CW-1:0] last,
  output logic          any,
  output logic [CW-1:0] pick
);

  always_comb begin
    int idx;
    any  = 1'b0;
    pick = '0;
    idx  = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!any && req[idx]) begin
        any  = 1'b1;
        pick = CW'(idx);
      end
    end
  end

endmodule

// File: rtl/txfp_pool_mem.sv
module txfp_pool_mem #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/txfifo_pool_mgr.sv
module txfifo_pool_mgr
  import txfp_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int DW       = 32,
  parameter int POOL_MAX = 128,
  localparam int CW = $clog2(NUM_CH),
  localparam int AW = $clog2(POOL_MAX),
  localparam int LW = AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_dis,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_ch,
  input  logic              cfg_en,
  input  logic [AW-1:0]     cfg_base,
  input  logic [LW-1:0]     cfg_len,
  output logic              cfg_err,
  input  logic              uf_clr_we,
  input  logic [NUM_CH-1:0] uf_clr_mask,
  output logic [NUM_CH-1:0] uflow,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic [CW-1:0]     dreq_ch,
  output logic [AW:0]       dreq_len,
  input  logic              dwr_valid,
  output logic              dwr_ready,
  input  logic [DW-1:0]     dwr_data,
  input  logic              ser_rd_valid,
  output logic              ser_rd_ready,
  input  logic [CW-1:0]     ser_ch,
  output logic [DW-1:0]     ser_rd_data
);

  localparam logic [DW-1:0] IDLE_WORD = {(DW/8){IDLE_BYTE}};

  // configuration fit check against the mode-dependent pool size
  logic [AW+1:0] cfg_sum, pool_sz;
  logic          cfg_reject, cfg_accept;

  assign cfg_sum    = (AW+2)'(cfg_base) + (((AW+2)'(cfg_len) + (AW+2)'(1)) << 1);
  assign pool_sz    = sub_dis ? (AW+2)'(POOL_MAX) : (AW+2)'(POOL_MAX / 2);
  assign cfg_reject = cfg_en && (cfg_sum > pool_sz);
  assign cfg_accept = cfg_we && !cfg_reject;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_err <= 1'b0;
    else if (cfg_we) cfg_err <= cfg_reject;
  end

  // arbiter / fill sequencer state
  arb_st_e       st_q;
  logic [CW-1:0] cur_ch, last_ch;
  logic [AW:0]   remain;
  logic          rr_any;
  logic [CW-1:0] rr_pick;
  logic          wr_fire;

  // per-channel context
  logic          en_v    [NUM_CH];
  logic [AW-1:0] base_v  [NUM_CH];
  logic [AW:0]   half_v  [NUM_CH];
  logic [AW:0]   size_v  [NUM_CH];
  logic [AW:0]   wptr_v  [NUM_CH];
  logic [AW:0]   rptr_v  [NUM_CH];
  logic [AW:0]   count_v [NUM_CH];
  logic [1:0]    need_v  [NUM_CH];
  logic          empty_v [NUM_CH];
  logic [NUM_CH-1:0] req_v;

  logic          rd_fire;
  logic          sel_empty;
  logic [AW:0]   sel_count, sel_size;

  assign rd_fire   = ser_rd_valid && ser_rd_ready;
  assign wr_fire   = (st_q == ARB_FILL) && dwr_valid;
  assign sel_empty = empty_v[ser_ch];
  assign sel_count = count_v[ser_ch];
  assign sel_size  = size_v[ser_ch];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ld_i, rd_i, miss_i, wr_i, done_i;
    assign ld_i   = cfg_accept && (cfg_ch == CW'(i));
    assign rd_i   = rd_fire && (ser_ch == CW'(i)) && !empty_v[i];
    assign miss_i = rd_fire && (ser_ch == CW'(i)) && empty_v[i];
    assign wr_i   = wr_fire && (cur_ch == CW'(i));
    assign done_i = wr_i && (remain == (AW+1)'(1));
    assign req_v[i] = en_v[i] && (need_v[i] != 2'd0);

    txfp_chan_ctx #(.AW(AW), .LW(LW)) ctx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld_i),
      .ld_en     (cfg_en),
      .ld_base   (cfg_base),
      .ld_len    (cfg_len),
      .rd_go     (rd_i),
      .rd_miss   (miss_i),
      .wr_go     (wr_i),
      .fill_done (done_i),
      .uf_clr    (uf_clr_we && uf_clr_mask[i]),
      .en        (en_v[i]),
      .base      (base_v[i]),
      .half      (half_v[i]),
      .size      (size_v[i]),
      .wptr      (wptr_v[i]),
      .rptr      (rptr_v[i]),
      .count     (count_v[i]),
      .need      (need_v[i]),
      .uflow     (uflow[i]),
      .empty     (empty_v[i])
    );
  end

  txfp_rr_pick #(.N(NUM_CH), .CW(CW)) rr_i (
    .req  (req_v),
    .last (last_ch),
    .any  (rr_any),
    .pick (rr_pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ARB_IDLE;
      cur_ch  <= '0;
      last_ch <= CW'(NUM_CH - 1);
      remain  <= '0;
    end else begin
      case (st_q)
        ARB_IDLE: if (rr_any) begin
          cur_ch  <= rr_pick;
          last_ch <= rr_pick;
          st_q    <= ARB_OFFER;
        end
        ARB_OFFER: if (dreq_ready) begin
          remain <= half_v[cur_ch];
          st_q   <= ARB_FILL;
        end
        ARB_FILL: if (dwr_valid) begin
          remain <= remain - (AW+1)'(1);
          if (remain == (AW+1)'(1)) st_q <= ARB_IDLE;
        end
        default: st_q <= ARB_IDLE;
      endcase
    end
  end

  assign dreq_valid = (st_q == ARB_OFFER);
  assign dreq_ch    = cur_ch;
  assign dreq_len   = half_v[cur_ch];
  assign dwr_ready  = (st_q == ARB_FILL);

  // shared storage
  logic [AW:0]   wsum, rsum;
  logic [DW-1:0] mem_rdata;

  assign wsum = (AW+1)'(base_v[cur_ch]) + wptr_v[cur_ch];
  assign rsum = (AW+1)'(base_v[ser_ch]) + rptr_v[ser_ch];

  txfp_pool_mem #(.DEPTH(POOL_MAX), .AW(AW), .DW(DW)) mem_i (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wsum[AW-1:0]),
    .wdata (dwr_data),
    .raddr (rsum[AW-1:0]),
    .rdata (mem_rdata)
  );

  assign ser_rd_ready = en_v[ser_ch];
  assign ser_rd_data  = sel_empty ? IDLE_WORD : mem_rdata;

endmodule

// File: rtl/txfifo_pool_mgr_chk.sv
module txfifo_pool_mgr_chk #(
  parameter int NUM_CH   = 32,
  parameter int DW       = 32,
  parameter int POOL_MAX = 128,
  localparam int CW = $clog2(NUM_CH),
  localparam int AW = $clog2(POOL_MAX),
  localparam int LW = AW - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sub_dis,
  input logic              cfg_we,
  input logic              cfg_en,
  input logic [AW-1:0]     cfg_base,
  input logic [LW-1:0]     cfg_len,
  input logic              cfg_err,
  input logic              uf_clr_we,
  input logic [NUM_CH-1:0] uflow,
  input logic              dreq_valid,
  input logic              dreq_ready,
  input logic [CW-1:0]     dreq_ch,
  input logic [AW:0]       dreq_len,
  input logic              dwr_ready,
  input logic              ser_rd_valid,
  input logic              ser_rd_ready,
  input logic [CW-1:0]     ser_ch,
  input logic [DW-1:0]     ser_rd_data,
  input logic              sel_empty,
  input logic [AW:0]       sel_count,
  input logic [AW:0]       sel_size
);

  localparam logic [DW-1:0] IDLE_WORD = {(DW/8){8'h7E}};

  logic [AW+1:0] chk_sum, chk_pool;
  assign chk_sum  = (AW+2)'(cfg_base) + (((AW+2)'(cfg_len) + (AW+2)'(1)) << 1);
  assign chk_pool = sub_dis ? (AW+2)'(POOL_MAX) : (AW+2)'(POOL_MAX / 2);

  p_cfg_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_en && (chk_sum > chk_pool) |=> cfg_err);

  p_offer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_ch) && $stable(dreq_len));

  p_one_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_ready |-> !dreq_valid);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_count <= sel_size);

  p_idle_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rd_valid && ser_rd_ready && sel_empty |-> ser_rd_data == IDLE_WORD);

  p_uflow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rd_valid && ser_rd_ready && sel_empty |=> uflow[$past(ser_ch)]);

  p_uflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !uf_clr_we |=> ((uflow & $past(uflow)) == $past(uflow)));

endmodule

bind txfifo_pool_mgr txfifo_pool_mgr_chk #(
  .NUM_CH(NUM_CH), .DW(DW), .POOL_MAX(POOL_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sub_dis(sub_dis), .cfg_we(cfg_we), .cfg_en(cfg_en),
  .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_err(cfg_err), .uf_clr_we(uf_clr_we),
  .uflow(uflow), .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_ch(dreq_ch),
  .dreq_len(dreq_len), .dwr_ready(dwr_ready), .ser_rd_valid(ser_rd_valid),
  .ser_rd_ready(ser_rd_ready), .ser_ch(ser_ch), .ser_rd_data(ser_rd_data),
  .sel_empty(sel_empty), .sel_count(sel_count), .sel_size(sel_size)
);

// File: tb/txfifo_pool_mgr_tb_top.sv
module txfifo_pool_mgr_tb_top;

  localparam int NUM_CH = 4;
  localparam int DW     = 32;
  localparam int POOL   = 128;
  localparam int CW     = $clog2(NUM_CH);
  localparam int AW     = $clog2(POOL);
  localparam int LW     = AW - 1;
  localparam logic [DW-1:0] IDLE = 32'h7E7E7E7E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_dis = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [CW-1:0] cfg_ch = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0;
  logic cfg_err;
  logic uf_clr_we = 1'b0;
  logic [NUM_CH-1:0] uf_clr_mask = '0;
  logic [NUM_CH-1:0] uflow;
  logic dreq_valid, dreq_ready = 1'b0;
  logic [CW-1:0] dreq_ch;
  logic [AW:0] dreq_len;
  logic dwr_valid = 1'b0, dwr_ready;
  logic [DW-1:0] dwr_data = '0;
  logic ser_rd_valid = 1'b0, ser_rd_ready;
  logic [CW-1:0] ser_ch = '0;
  logic [DW-1:0] ser_rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txfifo_pool_mgr #(.NUM_CH(NUM_CH), .DW(DW), .POOL_MAX(POOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .sub_dis(sub_dis),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_len(cfg_len), .cfg_err(cfg_err),
    .uf_clr_we(uf_clr_we), .uf_clr_mask(uf_clr_mask), .uflow(uflow),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_ch(dreq_ch), .dreq_len(dreq_len),
    .dwr_valid(dwr_valid), .dwr_ready(dwr_ready), .dwr_data(dwr_data),
    .ser_rd_valid(ser_rd_valid), .ser_rd_ready(ser_rd_ready), .ser_ch(ser_ch),
    .ser_rd_data(ser_rd_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input bit en, input int base, input int len);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CW'(ch); cfg_en = en;
    cfg_base = AW'(base); cfg_len = LW'(len);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic accept_offer(input int exp_ch, input int exp_len, input string tag);
    int waited = 0;
    @(negedge clk);
    while (!dreq_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " offer ch"}, 64'(dreq_ch), 64'(exp_ch));
    check({tag, " offer len"}, 64'(dreq_len), 64'(exp_len));
    @(negedge clk);
    @(negedge clk);
    check("R4 offer held", {62'd0, dreq_valid, (dreq_ch == CW'(exp_ch))}, 64'd3);
    dreq_ready = 1'b1;
    @(negedge clk);
    dreq_ready = 1'b0;
  endtask

  task automatic fill(input int n, input logic [DW-1:0] first);
    for (int k = 0; k < n; k++) begin
      check("R5 write ready", 64'(dwr_ready), 64'd1);
      dwr_valid = 1'b1; dwr_data = first + DW'(k);
      @(negedge clk);
    end
    dwr_valid = 1'b0;
    check("R5 ready drops after half", 64'(dwr_ready), 64'd0);
  endtask

  task automatic ser_read(input int ch, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    ser_rd_valid = 1'b1; ser_ch = CW'(ch);
    #1;
    check({tag, " ready"}, 64'(ser_rd_ready), 64'd1);
    check({tag, " data"}, 64'(ser_rd_data), 64'(exp));
    @(negedge clk);
    ser_rd_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R12 dreq_valid", 64'(dreq_valid), 64'd0);
    check("R12 dwr_ready", 64'(dwr_ready), 64'd0);
    check("R12 cfg_err", 64'(cfg_err), 64'd0);
    check("R12 uflow", 64'(uflow), 64'd0);
    ser_ch = 2'd1; #1;
    check("R12 channel disabled", 64'(ser_rd_ready), 64'd0);
  endtask

  task automatic t_config;
    sub_dis = 1'b0;
    cfg_write(2, 1'b1, 62, 1);          // ends at 66 > 64
    check("R1 reject in 64-word mode", 64'(cfg_err), 64'd1);
    ser_ch = 2'd2; #1;
    check("R2 rejected channel stays off", 64'(ser_rd_ready), 64'd0);
    check("R2 no offer after reject", 64'(dreq_valid), 64'd0);
    sub_dis = 1'b1;
    cfg_write(2, 1'b1, 62, 1);          // fits in 128
    check("R1 accept in 128-word mode", 64'(cfg_err), 64'd0);
    ser_ch = 2'd2; #1;
    check("R3 channel on", 64'(ser_rd_ready), 64'd1);
    cfg_write(0, 1'b1, 0, 3);
  endtask

  task automatic t_first_fills;
    accept_offer(2, 2, "R3 R10 first");
    fill(2, 32'hA000_0000);
    accept_offer(0, 4, "R10 rotate to ch0");
    fill(4, 32'hB000_0000);
    accept_offer(2, 2, "R3 R10 second half ch2");
    fill(2, 32'hA000_0002);
    accept_offer(0, 4, "R10 second half ch0");
    fill(4, 32'hB000_0004);
    @(negedge clk); @(negedge clk);
    check("R3 both halves served", 64'(dreq_valid), 64'd0);
  endtask

  task automatic t_drain;
    ser_read(2, 32'hA000_0000, "R6 order 0");
    @(negedge clk);
    check("R7 no offer mid-half", 64'(dreq_valid), 64'd0);
    ser_read(2, 32'hA000_0001, "R6 order 1");
    @(negedge clk); @(negedge clk);
    check("R7 offer after half drained", 64'(dreq_valid), 64'd1);
    check("R7 offer channel", 64'(dreq_ch), 64'd2);
    ser_read(2, 32'hA000_0002, "R6 order 2");
    ser_read(2, 32'hA000_0003, "R6 order 3");
    check("R8 no underflow yet", 64'(uflow), 64'd0);
    ser_read(2, IDLE, "R8 empty read idle");
    check("R8 underflow set", 64'(uflow), 64'b0100);
  endtask

  task automatic t_refill_wrap;
    accept_offer(2, 2, "R7 refill a");
    fill(2, 32'hC000_0000);
    accept_offer(2, 2, "R7 refill b");
    fill(2, 32'hC000_0002);
    ser_read(2, 32'hC000_0000, "R6 wrap to region start");
    ser_read(0, 32'hB000_0000, "R6 neighbour region intact");
  endtask

  task automatic t_uflow_clear;
    @(negedge clk);
    uf_clr_we = 1'b1; uf_clr_mask = 4'b0001;
    @(negedge clk);
    uf_clr_we = 1'b0;
    check("R9 zero mask bit keeps flag", 64'(uflow), 64'b0100);
    uf_clr_we = 1'b1; uf_clr_mask = 4'b0100;
    @(negedge clk);
    uf_clr_we = 1'b0;
    check("R9 one mask bit clears flag", 64'(uflow), 64'b0000);
  endtask

  task automatic t_disabled;
    @(negedge clk);
    ser_rd_valid = 1'b1; ser_ch = 2'd1;
    #1;
    check("R11 disabled ready low", 64'(ser_rd_ready), 64'd0);
    @(negedge clk);
    ser_rd_valid = 1'b0;
    check("R11 no underflow on disabled", 64'(uflow), 64'd0);
    ser_read(2, 32'hC000_0001, "R11 other fifo untouched");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_first_fills();
    t_drain();
    t_refill_wrap();
    t_uflow_clear();
    t_disabled();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule